// File: doc/BRIEF.md
# Two-Wire Serial Instruction Injector

This block is the host side of a two-wire debug and programming link. It drives a clock pin and a bidirectional data pin so that a target device executes one instruction per frame. A request carries a 4-bit command code and a 24-bit payload. The block clocks both out to the target, least significant bit first. Data changes on the falling edge of the generated clock, and the target samples it on the rising edge.

One command code asks the target to return its 16-bit visibility register. For that code the block sends only the command. It then releases the data line for a fixed turnaround of eight clocks and shifts in sixteen bits from the target, least significant bit first, sampling each bit on a falling edge. A response port hands the value back.

The serial clock rate is the system clock divided by a value supplied with each request. The serial clock stays low between frames. Sequencing whole programming algorithms is the job of the logic that issues requests.

Top module: `tw_injector`

## Requirements
- R1: While reset is asserted and right after it is released, pin_clk is low, pin_doe is low, req_ready is high and rsp_valid is low.
- R2: Every frame sends the 4-bit req_cmd on its first four serial clocks, least significant bit first. The target captures pin_dout on each rising edge of pin_clk.
- R3: For command code 4'b0000 (execute), the 24-bit req_data follows the command on serial clocks 4 to 27, least significant bit first. pin_doe is high for all 28 clocks.
- R4: For command code 4'b0001 (read), pin_doe is high for the four command clocks and low for the remaining 24 clocks. The last 16 of those clocks capture pin_din on each falling edge of pin_clk into rsp_data, least significant bit first.
- R5: rsp_valid is a single-cycle pulse that occurs once at the end of each read frame, in the cycle in which req_ready returns high. It never occurs for any other command code.
- R6: A request is accepted in a cycle where req_valid and req_ready are both high. req_ready stays low from the cycle after acceptance until the frame ends.
- R7: Each high or low phase of pin_clk lasts div_cfg+1 system clock cycles. pin_clk and pin_doe are low whenever req_ready is high.
- R8: pin_dout and pin_doe change only at the falling edge of pin_clk. They are stable throughout every high phase.
- R9: div_cfg is captured at acceptance. Changing it during a frame does not change that frame's clock timing.
- R10: Command codes other than 4'b0001 are sent as execute frames: 24 payload bits with pin_doe high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W | Half-period of the serial clock, minus one, in system cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_cmd | input | CMD_W | Command code |
| req_data | input | PAY_W | Instruction word for execute frames |
| rsp_valid | output | 1 | One-cycle pulse when read data is available |
| rsp_data | output | RD_W | Value returned by the target |
| pin_clk | output | 1 | Serial clock to the target |
| pin_dout | output | 1 | Serial data toward the target |
| pin_doe | output | 1 | Output enable for the data pin |
| pin_din | input | 1 | Serial data from the target |

## Verification
The clock-phase and response assertions assume that requests arrive only through the valid/ready handshake and that div_cfg is read only in the accepting cycle. They also assume that pin_din is settled when pin_clk falls. The bench's target model therefore changes pin_din a short delay after each falling edge, never in the same instant. The driver raises req_valid only while req_ready is high, and it changes div_cfg mid-frame to exercise the capture rule.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    SEG_CMD  = 2'd0,
    SEG_OUT  = 2'd1,
    SEG_TURN = 2'd2,
    SEG_IN   = 2'd3
  } seg_e;

  localparam logic [3:0] OP_EXEC = 4'h0;
  localparam logic [3:0] OP_READ = 4'h1;
endpackage

// File: rtl/tw_clkgen.sv
module tw_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  assign tick = busy && (cnt_q == div_q);
  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;
  assign sclk = sclk_q;

  always_comb begin
    div_d  = div_q;
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (start) begin
      div_d  = div_cfg;
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (busy) begin
      if (tick) begin
        cnt_d  = '0;
        sclk_d = ~sclk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end
endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int PAY_W  = 24,
  parameter int TURN_N = 8,
  parameter int RD_W   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_read,
  input  logic fall,
  output logic busy,
  output logic is_read,
  output logic done,
  output logic cap_en,
  output logic doe
);
  localparam int L1    = (PAY_W > RD_W) ? PAY_W : RD_W;
  localparam int L2    = (L1 > TURN_N) ? L1 : TURN_N;
  localparam int L3    = (L2 > CMD_W) ? L2 : CMD_W;
  localparam int CNT_W = (L3 > 1) ? $clog2(L3) : 1;

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic [CNT_W-1:0] last_idx;
  logic             last;

  always_comb begin
    unique case (seg_q)
      SEG_CMD:  last_idx = CNT_W'(CMD_W - 1);
      SEG_OUT:  last_idx = CNT_W'(PAY_W - 1);
      SEG_TURN: last_idx = CNT_W'(TURN_N - 1);
      default:  last_idx = CNT_W'(RD_W - 1);
    endcase
  end

  assign last    = (bcnt_q == last_idx);
  assign done    = busy_q && fall && last && ((seg_q == SEG_OUT) || (seg_q == SEG_IN));
  assign cap_en  = busy_q && fall && (seg_q == SEG_IN);
  assign doe     = busy_q && ((seg_q == SEG_CMD) || (seg_q == SEG_OUT));
  assign busy    = busy_q;
  assign is_read = rd_q;

  always_comb begin
    seg_d  = seg_q;
    bcnt_d = bcnt_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    if (start) begin
      busy_d = 1'b1;
      seg_d  = SEG_CMD;
      bcnt_d = '0;
      rd_d   = start_read;
    end else if (busy_q && fall) begin
      if (last) begin
        bcnt_d = '0;
        unique case (seg_q)
          SEG_CMD:  seg_d = rd_q ? SEG_TURN : SEG_OUT;
          SEG_TURN: seg_d = SEG_IN;
          default: begin
            busy_d = 1'b0;
            seg_d  = SEG_CMD;
          end
        endcase
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_CMD;
      bcnt_q <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      bcnt_q <= bcnt_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
  parameter int WIDTH = 28,
  parameter bit TX    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] par_out
);
  logic [WIDTH-1:0] sr_q, sr_d;

  generate
    if (TX) begin : g_tx
      always_comb begin
        sr_d = sr_q;
        if (load)          sr_d = load_val;
        else if (shift_en) sr_d = {1'b0, sr_q[WIDTH-1:1]};
      end
    end else begin : g_rx
      always_comb begin
        sr_d = sr_q;
        if (load)          sr_d = load_val;
        else if (shift_en) sr_d = {ser_in, sr_q[WIDTH-1:1]};
      end
    end
  endgenerate

  assign ser_out = sr_q[0];
  assign par_out = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/tw_injector.sv
module tw_injector
  import tw_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CMD_W  = 4,
  parameter int PAY_W  = 24,
  parameter int TURN_N = 8,
  parameter int RD_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [PAY_W-1:0] req_data,
  output logic             rsp_valid,
  output logic [RD_W-1:0]  rsp_data,
  output logic             pin_clk,
  output logic             pin_dout,
  output logic             pin_doe,
  input  logic             pin_din
);
  localparam int FRM_W = CMD_W + PAY_W;

  logic             busy, is_read, done, cap_en, fall, rise;
  logic             accept, req_is_read;
  logic [FRM_W-1:0] tx_load, tx_par;
  logic             rsp_q, rsp_d;

  assign req_ready   = !busy;
  assign accept      = req_valid && req_ready;
  assign req_is_read = (req_cmd == CMD_W'(OP_READ));
  assign tx_load     = req_is_read ? {{PAY_W{1'b0}}, req_cmd} : {req_data, req_cmd};

  tw_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .busy    (busy),
    .div_cfg (div_cfg),
    .sclk    (pin_clk),
    .rise    (rise),
    .fall    (fall)
  );

  tw_seq #(.CMD_W(CMD_W), .PAY_W(PAY_W), .TURN_N(TURN_N), .RD_W(RD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_read (req_is_read),
    .fall       (fall),
    .busy       (busy),
    .is_read    (is_read),
    .done       (done),
    .cap_en     (cap_en),
    .doe        (pin_doe)
  );

  tw_shift #(.WIDTH(FRM_W), .TX(1'b1)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (tx_load),
    .shift_en (fall && busy),
    .ser_in   (1'b0),
    .ser_out  (pin_dout),
    .par_out  (tx_par)
  );

  logic rx_unused;
  tw_shift #(.WIDTH(RD_W), .TX(1'b0)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (1'b0),
    .load_val ({RD_W{1'b0}}),
    .shift_en (cap_en),
    .ser_in   (pin_din),
    .ser_out  (rx_unused),
    .par_out  (rsp_data)
  );

  always_comb begin
    rsp_d = done && is_read;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q;

  logic unused_ok;
  assign unused_ok = ^{tx_par, rise, rx_unused};
endmodule

// File: rtl/tw_injector_chk.sv
module tw_injector_chk
  import tw_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CMD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_cfg,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CMD_W-1:0] req_cmd,
  input logic             rsp_valid,
  input logic             pin_clk,
  input logic             pin_dout,
  input logic             pin_doe
);
  logic [DIV_W:0]   hl_q;
  logic [DIV_W-1:0] dl_q;
  logic             clk_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q  <= '0;
      dl_q  <= '0;
      clk_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      clk_q <= pin_clk;
      if (req_valid && req_ready) begin
        hl_q <= '0;
        dl_q <= div_cfg;
        rd_q <= (req_cmd == CMD_W'(OP_READ));
      end else if (pin_clk != clk_q) begin
        hl_q <= (DIV_W+1)'(1);
      end else begin
        hl_q <= hl_q + 1'b1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!pin_clk && !pin_doe)); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pin_clk |-> !req_ready); // R6

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clk && $past(pin_clk)) |-> ($stable(pin_dout) && $stable(pin_doe))); // R8

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

  AST_RSP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rd_q && req_ready)); // R5

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clk != clk_q) |-> (hl_q == ({1'b0, dl_q} + 1'b1))); // R7 R9
endmodule

bind tw_injector tw_injector_chk #(.DIV_W(DIV_W), .CMD_W(CMD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_cfg   (div_cfg),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cmd   (req_cmd),
  .rsp_valid (rsp_valid),
  .pin_clk   (pin_clk),
  .pin_dout  (pin_dout),
  .pin_doe   (pin_doe)
);

// File: tb/tw_injector_test.sv
module tw_injector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_cfg = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cmd = '0;
  logic [23:0] req_data = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        pin_clk, pin_dout, pin_doe;
  logic        pin_din = 1'b0;

  always #2 clk = ~clk;

  tw_injector uut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pin_clk(pin_clk), .pin_dout(pin_dout), .pin_doe(pin_doe),
    .pin_din(pin_din)
  );

  typedef struct {
    logic [3:0]  c;
    logic [23:0] d;
    logic        rd;
  } frm_t;

  frm_t        exp_q[$];
  logic [15:0] rsp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, rises = 0, last_rise = 0;
  int cur_div = 0, rsp_cnt = 0, n_reads = 0;
  logic        tgt_rd = 1'b0;
  logic [15:0] tgt_val = '0;
  logic [27:0] bits_v = '0, oes_v = '0;
  logic        pclk_prev = 1'b0, dout_prev = 1'b0, doe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle counter and watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // R8: outputs held during high phase
  always @(negedge clk) begin
    if (rst_n && pin_clk && pclk_prev)
      chk(pin_dout == dout_prev && pin_doe == doe_prev, "R8 data stable high",
          {pin_dout, pin_doe}, {dout_prev, doe_prev});
    pclk_prev = pin_clk;
    dout_prev = pin_dout;
    doe_prev  = pin_doe;
  end

  // Target model: capture on rising edge, check period (R7, R9)
  always @(posedge pin_clk) begin
    if (rises > 0)
      chk(cyc - last_rise == 2 * (cur_div + 1), "R7 R9 period", cyc - last_rise, 2 * (cur_div + 1));
    last_rise = cyc;
    if (rises < 28) begin
      bits_v[rises] = pin_dout;
      oes_v[rises]  = pin_doe;
    end
    rises++;
  end

  // Target model: drive read data after falling edge; frame monitor
  always @(negedge pin_clk) begin
    if (tgt_rd && rises >= 12 && rises < 28) pin_din <= #1 tgt_val[rises-12];
    if (rises == 28) begin
      frm_t f;
      logic [27:0] exp_oe;
      rises = 0;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected frame", 0, 0);
      end else begin
        f = exp_q.pop_front();
        chk(bits_v[3:0] == f.c, "R2 command bits", bits_v[3:0], f.c);
        exp_oe = f.rd ? 28'h000000F : 28'hFFFFFFF;
        chk(oes_v == exp_oe, f.rd ? "R4 read output enable" : "R3 R10 output enable", oes_v, exp_oe);
        if (!f.rd)
          chk(bits_v[27:4] == f.d, "R3 R10 payload bits", bits_v[27:4], f.d);
      end
    end
  end

  // Response monitor (R4, R5)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_cnt++;
      if (rsp_q.size() == 0) chk(1'b0, "R5 response on non-read", rsp_data, 0);
      else begin
        logic [15:0] e;
        e = rsp_q.pop_front();
        chk(rsp_data == e, "R4 read data", rsp_data, e);
        chk(req_ready, "R5 pulse at frame end", req_ready, 1);
      end
    end
  end

  task automatic send(input logic [3:0] c, input logic [23:0] d, input logic [15:0] rv,
                      input int dv, input int dv_mid);
    frm_t f;
    while (!req_ready) @(negedge clk);
    cur_div  = dv;
    tgt_rd   = (c == 4'h1);
    tgt_val  = rv;
    div_cfg  = 8'(dv);
    req_cmd  = c;
    req_data = d;
    f.c = c; f.d = d; f.rd = (c == 4'h1);
    exp_q.push_back(f);
    if (f.rd) begin
      rsp_q.push_back(rv);
      n_reads++;
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R6 ready low after accept", req_ready, 0);
    if (dv_mid >= 0) div_cfg = 8'(dv_mid);
    while (!req_ready) @(negedge clk);
    chk(!pin_clk && !pin_doe, "R7 idle clock low", {pin_clk, pin_doe}, 0);
    repeat (3) @(negedge clk);
    chk(rsp_cnt == n_reads, "R5 response count", rsp_cnt, n_reads);
    chk(exp_q.size() == 0, "R2 frame completed", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pin_clk && !pin_doe && req_ready && !rsp_valid, "R1 in reset",
        {pin_clk, pin_doe, req_ready, rsp_valid}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pin_clk && !pin_doe && req_ready && !rsp_valid, "R1 after reset",
        {pin_clk, pin_doe, req_ready, rsp_valid}, 4'b0010);

    send(4'h0, 24'h000000, 16'h0, 1, -1);    // R3 no-op
    send(4'h0, 24'h040200, 16'h0, 0, -1);    // R3 jump
    send(4'h1, 24'h0,      16'hA5C3, 2, -1); // R4 read
    send(4'h1, 24'hFFFFFF, 16'h8001, 0, 5);  // R4 R9 div change mid-frame
    send(4'hA, 24'hFFFFFF, 16'h0, 3, 0);     // R10 other code, R9
    send(4'h0, 24'h123456, 16'h0, 1, -1);    // R2 R3
    send(4'h1, 24'h0,      16'hFFFF, 1, -1); // R4
    send(4'hF, 24'hC0FFEE, 16'h0, 0, -1);    // R10

    repeat (5) @(negedge clk);
    chk(!rsp_valid && req_ready, "R5 quiet at end", {rsp_valid, req_ready}, 2'b01);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule